// File: doc/BRIEF.md
# Low Pin Count I/O Cycle Target

This block sits on the peripheral side of a Low Pin Count bus. It samples the active-low frame strobe and the four-bit LAD bus on every clock. It recognises the start nibble, the cycle type and the 16-bit I/O address, and it answers host I/O reads and writes aimed at any of several mailbox channels. Each channel compares the address against its own programmable base. On a host write the channel keeps the data byte, raises a "byte waiting" flag and can pulse a receive interrupt. The local processor collects the byte and clears the flag with a one-clock read strobe. A host read returns a byte that the local side placed in the channel's outbound register beforehand.

The target stays off the bus when the address does not belong to an enabled channel, when the cycle is not an I/O cycle, and when every channel is disabled. If the frame strobe drops in the middle of a cycle, the cycle is abandoned: the target releases LAD at once and waits for a fresh start.

Top module: `lpc_io_target`

## Requirements
- R1: While reset is held and in the first clock after it, lad_oe is 0, and ibf, rx_irq and idr_data are all zero.
- R2: A cycle opens only when lframe_n is sampled 0 with LAD = 0000 while the target is idle. The start may last several clocks, and the type nibble is taken on the first clock with lframe_n high. A low frame strobe with any other LAD value opens nothing.
- R3: Type nibble 0000 selects an I/O read and 0010 an I/O write. Every other type (memory, firmware memory, DMA, bus master) receives no response and changes no channel state.
- R4: The address arrives as four nibbles, most significant first. A channel is selected only if it is enabled and its base equals the address. When several channels qualify, the lowest index wins.
- R5: On a matched write, the data byte follows the address as two nibbles, low nibble first, and the host then holds two turnaround clocks. The target drives 0000 for one clock (clock 10 counted from the start nibble), drives 1111 for one clock, and then releases LAD. The channel's idr_data byte and its ibf bit take the new values in the clock after the 0000 nibble.
- R6: On a matched read, after the address and two host turnaround clocks, the target drives 0000 at clock 8. It then drives the low and the high nibble of that channel's outbound byte, then 1111, and releases LAD at clock 12.
- R7: A completed write pulses rx_irq of that channel for exactly one clock, in the clock after the 0000 nibble, if irq_en of that channel is 1. If irq_en is 0, no pulse occurs.
- R8: A one-clock loc_rd pulse for a channel clears its ibf bit at the next clock edge and leaves idr_data unchanged.
- R9: For an I/O cycle whose address matches no enabled channel, lad_oe stays 0 for the whole cycle and no channel state changes.
- R10: With chan_en all zero, the target opens no cycle, never asserts lad_oe, and changes no channel state.
- R11: If lframe_n is sampled 0 in any clock after the type nibble, lad_oe is 0 from the next clock on. A write aborted at or before its 0000 nibble does not update the channel, and the target accepts the next normal start.
- R12: A one-clock loc_we pulse for a channel loads loc_wdata into that channel's outbound byte, and later host reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Sampled value of the LAD bus |
| lad_out | output | 4 | Nibble the target drives onto LAD |
| lad_oe | output | 1 | High while the target drives LAD |
| chan_en | input | NCH | Per-channel enable |
| chan_addr | input | NCH*AW | Per-channel I/O base, channel i at bits [i*AW +: AW] |
| irq_en | input | NCH | Per-channel receive interrupt enable |
| loc_rd | input | NCH | Local read strobe; clears that channel's ibf |
| loc_we | input | NCH | Local write strobe for the outbound byte |
| loc_wdata | input | DW | Byte stored on loc_we |
| idr_data | output | NCH*DW | Last byte each channel received from the host |
| ibf | output | NCH | Per-channel byte-waiting flag |
| rx_irq | output | NCH | One-clock receive interrupt pulse per channel |

## Verification
Directed cycles come first. They cover single-channel reads and writes, two channels sharing one base (to tell priority from a blind OR), a lengthened start and a wrong start nibble (to tell start detection from mere strobe watching), non-I/O type nibbles, and aborts before, during and after the ready nibble (to separate abandoning a cycle from completing it). A seeded random mix then varies channel bases, enables, interrupt enables, type nibbles, addresses, data, abort points and interleaved local reads and writes. For every cycle the bench predicts the drive pattern on LAD clock by clock, the flags, the stored bytes and the interrupt count. Together these show that an address or type that almost matches never reaches the bus.

// File: rtl/lpct_pkg.sv
`timescale 1ns/1ps
package lpct_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] NIB_START   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_IO_RD   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_IO_WR   = 4'b0010;
    localparam logic [NIB_W-1:0] NIB_READY   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_TURN    = 4'b1111;

    // bus phase of the clock currently on the wires
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTYPE,
        PH_ADDR,
        PH_WDAT,
        PH_HTAR,
        PH_SYNC,
        PH_RDAT,
        PH_PTAR
    } phase_e;

    function automatic logic phase_busy(input phase_e p);
        return (p != PH_IDLE) && (p != PH_CTYPE);
    endfunction

endpackage

// File: rtl/lpct_channel.sv
`timescale 1ns/1ps
module lpct_channel #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] cand_addr,
    output logic          hit,
    input  logic          wr_commit,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_en,
    input  logic          loc_rd,
    input  logic          loc_we,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] idr,
    output logic          ibf,
    output logic          irq,
    output logic [DW-1:0] odr
);

    typedef struct packed {
        logic [DW-1:0] idr;
        logic          ibf;
        logic          irq;
        logic [DW-1:0] odr;
    } chan_t;

    chan_t ch_q, ch_d;

    assign hit = en && (base_addr == cand_addr);

    always_comb begin
        ch_d     = ch_q;
        ch_d.irq = 1'b0;
        if (loc_rd) begin
            ch_d.ibf = 1'b0;
        end
        if (loc_we) begin
            ch_d.odr = loc_wdata;
        end
        if (wr_commit) begin
            ch_d.idr = wr_data;
            ch_d.ibf = 1'b1;
            ch_d.irq = irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign idr = ch_q.idr;
    assign ibf = ch_q.ibf;
    assign irq = ch_q.irq;
    assign odr = ch_q.odr;

    // R5: a committed host byte lands in the inbound register with the flag up
    a_r5_idr_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (ch_q.ibf && ch_q.idr == $past(wr_data)));

    // R8: local read clears the flag when no host byte arrives at once
    a_r8_local_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && !wr_commit) |=> !ch_q.ibf);

    // R7: the receive interrupt never lasts two clocks
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.irq |=> !ch_q.irq);

    // R12: local write loads the outbound byte
    a_r12_odr_load: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |=> (ch_q.odr == $past(loc_wdata)));

endmodule

// File: rtl/lpct_cycle_fsm.sv
`timescale 1ns/1ps
module lpct_cycle_fsm
    import lpct_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lframe_n,
    input  logic [NIB_W-1:0]     lad_in,
    input  logic                 any_en,
    input  logic [NCH-1:0]       hit_vec,
    input  logic [DW-1:0]        rd_byte,
    output logic [AW-1:0]        cand_addr,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] sel,
    output logic [NCH-1:0]       commit_vec,
    output logic [DW-1:0]        wr_data,
    output logic [NIB_W-1:0]     lad_out,
    output logic                 lad_oe
);

    localparam int ANIB  = AW / NIB_W;
    localparam int DNIB  = DW / NIB_W;
    localparam int TAR_N = 2;
    localparam int CMAX  = (ANIB > DNIB) ? ANIB : DNIB;
    localparam int CW    = (CMAX > 1) ? $clog2(CMAX) : 1;
    localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        phase_e              ph;
        logic [AW-NIB_W-1:0] addr;
        logic [DW-1:0]       wdat;
        logic [DW-1:0]       rsh;
        logic [CW-1:0]       cnt;
        logic                wr;
        logic                hit;
        logic [IW-1:0]       sel;
    } fsm_t;

    fsm_t q, d;

    logic          any_hit;
    logic [IW-1:0] sel_pick;

    // lowest enabled matching channel wins
    always_comb begin
        any_hit  = 1'b0;
        sel_pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                sel_pick = IW'(i);
            end
        end
    end

    assign cand_addr = {q.addr, lad_in};

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (any_en && !lframe_n && lad_in == NIB_START) begin
                    d.ph = PH_CTYPE;
                end
            end
            PH_CTYPE: begin
                if (!lframe_n) begin
                    if (lad_in != NIB_START) begin
                        d.ph = PH_IDLE;
                    end
                end else if (lad_in == NIB_IO_RD || lad_in == NIB_IO_WR) begin
                    d.wr  = (lad_in == NIB_IO_WR);
                    d.cnt = '0;
                    d.ph  = PH_ADDR;
                end else begin
                    d.ph = PH_IDLE;
                end
            end
            PH_ADDR: begin
                d.addr = {q.addr[AW-2*NIB_W-1:0], lad_in};
                if (q.cnt == CW'(ANIB - 1)) begin
                    d.hit = any_hit;
                    d.sel = sel_pick;
                    d.cnt = '0;
                    d.ph  = q.wr ? PH_WDAT : PH_HTAR;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_WDAT: begin
                d.wdat = {lad_in, q.wdat[DW-1:NIB_W]};
                if (q.cnt == CW'(DNIB - 1)) begin
                    d.cnt = '0;
                    d.ph  = PH_HTAR;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_HTAR: begin
                if (q.cnt == CW'(TAR_N - 1)) begin
                    d.cnt = '0;
                    d.ph  = PH_SYNC;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_SYNC: begin
                d.rsh = rd_byte;
                d.cnt = '0;
                d.ph  = q.wr ? PH_PTAR : PH_RDAT;
            end
            PH_RDAT: begin
                d.rsh = q.rsh >> NIB_W;
                if (q.cnt == CW'(DNIB - 1)) begin
                    d.cnt = '0;
                    d.ph  = PH_PTAR;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_PTAR: begin
                if (q.cnt == CW'(TAR_N - 1)) begin
                    d.cnt = '0;
                    d.hit = 1'b0;
                    d.ph  = PH_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: begin
                d.ph = PH_IDLE;
            end
        endcase
        // frame strobe inside a running cycle: abandon it
        if (phase_busy(q.ph) && !lframe_n) begin
            d.ph  = PH_IDLE;
            d.hit = 1'b0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sel     = q.sel;
    assign wr_data = q.wdat;

    always_comb begin
        commit_vec = '0;
        if (q.ph == PH_SYNC && lframe_n && q.wr && q.hit) begin
            commit_vec = NCH'(1) << q.sel;
        end
    end

    always_comb begin
        lad_oe  = 1'b0;
        lad_out = NIB_TURN;
        if (q.hit) begin
            case (q.ph)
                PH_SYNC: begin
                    lad_oe  = 1'b1;
                    lad_out = NIB_READY;
                end
                PH_RDAT: begin
                    lad_oe  = 1'b1;
                    lad_out = q.rsh[NIB_W-1:0];
                end
                PH_PTAR: begin
                    lad_oe  = (q.cnt == '0);
                    lad_out = NIB_TURN;
                end
                default: begin
                    lad_oe = 1'b0;
                end
            endcase
        end
    end

    // R2: idle holds unless the start nibble arrives under a low strobe
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && (lframe_n || lad_in != NIB_START)) |=> (q.ph == PH_IDLE));

    // R10: with every channel off the target stays idle and silent
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !any_en) |=> (q.ph == PH_IDLE && !lad_oe));

    // R11: a low strobe inside a cycle releases LAD on the next clock
    a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_busy(q.ph) && !lframe_n) |=> !lad_oe);

    // R5: a committed write is followed by the driven turnaround nibble
    a_r5_commit_then_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_vec) |=> (lad_oe && lad_out == NIB_TURN));

endmodule

// File: rtl/lpc_io_target.sv
`timescale 1ns/1ps
module lpc_io_target
    import lpct_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*AW-1:0] chan_addr,
    input  logic [NCH-1:0]    irq_en,
    input  logic [NCH-1:0]    loc_rd,
    input  logic [NCH-1:0]    loc_we,
    input  logic [DW-1:0]     loc_wdata,
    output logic [NCH*DW-1:0] idr_data,
    output logic [NCH-1:0]    ibf,
    output logic [NCH-1:0]    rx_irq
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [AW-1:0]  cand_addr;
    logic [NCH-1:0] hit_vec;
    logic [NCH-1:0] commit_vec;
    logic [IW-1:0]  sel;
    logic [DW-1:0]  wr_data;
    logic [DW-1:0]  rd_byte;
    logic [DW-1:0]  odr_w [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        lpct_channel #(
            .AW(AW),
            .DW(DW)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (chan_en[g]),
            .base_addr (chan_addr[g*AW +: AW]),
            .cand_addr (cand_addr),
            .hit       (hit_vec[g]),
            .wr_commit (commit_vec[g]),
            .wr_data   (wr_data),
            .irq_en    (irq_en[g]),
            .loc_rd    (loc_rd[g]),
            .loc_we    (loc_we[g]),
            .loc_wdata (loc_wdata),
            .idr       (idr_data[g*DW +: DW]),
            .ibf       (ibf[g]),
            .irq       (rx_irq[g]),
            .odr       (odr_w[g])
        );
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == IW'(i)) begin
                rd_byte = odr_w[i];
            end
        end
    end

    lpct_cycle_fsm #(
        .NCH(NCH),
        .AW (AW),
        .DW (DW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lframe_n   (lframe_n),
        .lad_in     (lad_in),
        .any_en     (|chan_en),
        .hit_vec    (hit_vec),
        .rd_byte    (rd_byte),
        .cand_addr  (cand_addr),
        .sel        (sel),
        .commit_vec (commit_vec),
        .wr_data    (wr_data),
        .lad_out    (lad_out),
        .lad_oe     (lad_oe)
    );

endmodule

// File: tb/tb_lpc_io_target.sv
`timescale 1ns/1ps
module tb_lpc_io_target;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lframe_n;
    logic [3:0]        lad_in;
    logic [3:0]        lad_out;
    logic              lad_oe;
    logic [NCH-1:0]    chan_en;
    logic [NCH*AW-1:0] chan_addr;
    logic [NCH-1:0]    irq_en;
    logic [NCH-1:0]    loc_rd;
    logic [NCH-1:0]    loc_we;
    logic [DW-1:0]     loc_wdata;
    logic [NCH*DW-1:0] idr_data;
    logic [NCH-1:0]    ibf;
    logic [NCH-1:0]    rx_irq;

    lpc_io_target #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .chan_en(chan_en),
        .chan_addr(chan_addr), .irq_en(irq_en), .loc_rd(loc_rd),
        .loc_we(loc_we), .loc_wdata(loc_wdata), .idr_data(idr_data),
        .ibf(ibf), .rx_irq(rx_irq)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench model
    logic [15:0]    m_addr [NCH];
    logic [NCH-1:0] m_en;
    logic [NCH-1:0] m_ie;
    logic [7:0]     m_odr  [NCH];
    logic [7:0]     m_idr  [NCH];
    logic [NCH-1:0] m_ibf;

    logic [16:0] log_oe;
    logic [15:0] log_lad;
    int          irq_cnt [NCH];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog run did not end");
        report();
    end

    function automatic int match_of(input logic [15:0] a);
        for (int i = 0; i < NCH; i++) begin
            if (m_en[i] && m_addr[i] == a) return i;
        end
        return -1;
    endfunction

    task automatic apply_cfg();
        chan_en = m_en;
        irq_en  = m_ie;
        for (int i = 0; i < NCH; i++) chan_addr[i*AW +: AW] = m_addr[i];
    endtask

    task automatic bus_cycle(input logic lf, input logic [3:0] v, input int c);
        @(negedge clk);
        lframe_n = lf;
        lad_in   = v;
        #1;
        if (c >= 0 && c < 17) log_oe[c] = lad_oe;
        if (c >= 8 && c <= 11) log_lad[(c-8)*4 +: 4] = lad_out;
        for (int i = 0; i < NCH; i++) if (rx_irq[i]) irq_cnt[i]++;
    endtask

    task automatic loc_read(input int ch);
        @(negedge clk);
        loc_rd = NCH'(1) << ch;
        @(negedge clk);
        loc_rd = '0;
        m_ibf[ch] = 1'b0;
        #1;
        chk(ibf == m_ibf, "R8", "ibf after local read", ibf, m_ibf);
        chk(idr_data == {m_idr[3], m_idr[2], m_idr[1], m_idr[0]}, "R8",
            "idr kept on local read", idr_data, {m_idr[3], m_idr[2], m_idr[1], m_idr[0]});
    endtask

    task automatic loc_write(input int ch, input logic [7:0] v);
        @(negedge clk);
        loc_we    = NCH'(1) << ch;
        loc_wdata = v;
        @(negedge clk);
        loc_we    = '0;
        m_odr[ch] = v;
    endtask

    // one host cycle: sn start nibble, pre extra start clocks, ct type, ab abort clock (<2 none)
    task automatic run_cyc(input logic [3:0] sn, input int pre, input logic [3:0] ct,
                           input logic [15:0] a, input logic [7:0] wd, input int ab);
        bit          io, wr, commit;
        int          m;
        logic [16:0] e_oe;
        logic [15:0] e_lad, e_msk;
        string       tag;
        log_oe  = '0;
        log_lad = '0;
        for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
        for (int k = 0; k < pre; k++) bus_cycle(1'b0, 4'h0, -1);
        for (int c = 0; c < 17; c++) begin
            logic       lf;
            logic [3:0] v;
            lf = 1'b1;
            v  = 4'hF;
            if (c == 0) begin lf = 1'b0; v = sn; end
            else if (c == 1) v = ct;
            else if (c <= 5) v = a[(5-c)*4 +: 4];
            else if (ct == 4'b0010 && c == 6) v = wd[3:0];
            else if (ct == 4'b0010 && c == 7) v = wd[7:4];
            if (ab >= 2 && c >= ab && c < ab + 4) begin lf = 1'b0; v = 4'hF; end
            bus_cycle(lf, v, c);
        end
        io = (sn == 4'h0) && (ct == 4'b0000 || ct == 4'b0010);
        wr = (ct == 4'b0010);
        m  = match_of(a);
        e_oe  = '0;
        e_lad = '0;
        e_msk = '0;
        if (io && m >= 0) begin
            if (wr) begin
                e_oe[10] = 1'b1; e_oe[11] = 1'b1;
                e_lad[11:8] = 4'h0; e_lad[15:12] = 4'hF; e_msk[15:8] = 8'hFF;
            end else begin
                e_oe[11:8] = 4'hF;
                e_lad = {4'hF, m_odr[m][7:4], m_odr[m][3:0], 4'h0};
                e_msk = 16'hFFFF;
            end
            if (ab >= 2) begin
                for (int c = 0; c < 17; c++) if (c > ab) e_oe[c] = 1'b0;
                for (int c = 8; c <= 11; c++) if (c > ab) e_msk[(c-8)*4 +: 4] = 4'h0;
            end
        end
        commit = io && wr && (m >= 0) && (ab < 2 || ab > 10);
        if (sn != 4'h0)        tag = "R2";
        else if (!io)          tag = "R3";
        else if (m_en == '0)   tag = "R10";
        else if (m < 0)        tag = "R9";
        else if (ab >= 2)      tag = "R11";
        else if (wr)           tag = "R5";
        else                   tag = "R6";
        chk(log_oe == e_oe, tag, "lad_oe per clock", log_oe, e_oe);
        chk((log_lad & e_msk) == (e_lad & e_msk), tag, "driven nibbles",
            log_lad & e_msk, e_lad & e_msk);
        if (commit) begin
            m_idr[m] = wd;
            m_ibf[m] = 1'b1;
        end
        chk(ibf == m_ibf, (tag == "R6") ? "R5" : tag, "ibf", ibf, m_ibf);
        chk(idr_data == {m_idr[3], m_idr[2], m_idr[1], m_idr[0]}, (tag == "R6") ? "R5" : tag,
            "idr_data", idr_data, {m_idr[3], m_idr[2], m_idr[1], m_idr[0]});
        for (int i = 0; i < NCH; i++) begin
            int e_irq;
            e_irq = (commit && i == m && m_ie[i]) ? 1 : 0;
            chk(irq_cnt[i] == e_irq, "R7", "rx_irq pulse count", irq_cnt[i], e_irq);
        end
    endtask

    function automatic logic [15:0] pick_addr();
        int r;
        r = int'($urandom % 6);
        case (r)
            0: return 16'h0060;
            1: return 16'h0064;
            2: return 16'h0CA2;
            3: return 16'h0CA3;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        lframe_n  = 1'b1;
        lad_in    = 4'hF;
        loc_rd    = '0;
        loc_we    = '0;
        loc_wdata = '0;
        m_en  = 4'b1111;
        m_ie  = 4'b0101;
        m_ibf = '0;
        m_addr[0] = 16'h0060; m_addr[1] = 16'h0064;
        m_addr[2] = 16'h0CA2; m_addr[3] = 16'h1234;
        for (int i = 0; i < NCH; i++) begin m_odr[i] = '0; m_idr[i] = '0; end
        apply_cfg();
        repeat (3) @(negedge clk);
        #1;
        chk(lad_oe == 1'b0 && ibf == '0 && rx_irq == '0 && idr_data == '0, "R1",
            "outputs in reset", {lad_oe, ibf, rx_irq}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(lad_oe == 1'b0 && ibf == '0 && rx_irq == '0 && idr_data == '0, "R1",
            "outputs after reset", {lad_oe, ibf, rx_irq}, 0);

        // R12 then R6: outbound byte returned by a host read
        loc_write(1, 8'hA5);
        run_cyc(4'h0, 0, 4'b0000, 16'h0064, 8'h00, -1);
        // R5 and R7: write with and without interrupt enable
        run_cyc(4'h0, 0, 4'b0010, 16'h0060, 8'h3C, -1);
        run_cyc(4'h0, 0, 4'b0010, 16'h0064, 8'hC3, -1);
        // R8
        loc_read(0);
        // R4: two channels on one base, lowest index wins, then disabled one skipped
        m_addr[3] = 16'h0CA2;
        apply_cfg();
        run_cyc(4'h0, 0, 4'b0010, 16'h0CA2, 8'h77, -1);
        chk(ibf[2] == 1'b1 && ibf[3] == 1'b0, "R4", "priority of lower channel", ibf, 4'b0100);
        m_en[2] = 1'b0;
        apply_cfg();
        run_cyc(4'h0, 0, 4'b0010, 16'h0CA2, 8'h88, -1);
        chk(ibf[3] == 1'b1 && idr_data[31:24] == 8'h88, "R4", "disabled channel skipped",
            idr_data[31:24], 8'h88);
        m_en[2] = 1'b1;
        apply_cfg();
        // R9: unmatched address
        run_cyc(4'h0, 0, 4'b0010, 16'h0070, 8'h11, -1);
        run_cyc(4'h0, 0, 4'b0000, 16'h0061, 8'h00, -1);
        // R3: memory and DMA types
        run_cyc(4'h0, 0, 4'b0100, 16'h0060, 8'h22, -1);
        run_cyc(4'h0, 0, 4'b0110, 16'h0060, 8'h22, -1);
        run_cyc(4'h0, 0, 4'b1000, 16'h0064, 8'h22, -1);
        // R2: lengthened start and wrong start nibble
        run_cyc(4'h0, 2, 4'b0010, 16'h0064, 8'h5A, -1);
        run_cyc(4'h5, 0, 4'b0010, 16'h0060, 8'h99, -1);
        // R11: aborts before, at and after the ready nibble, and during a read
        loc_read(0);
        run_cyc(4'h0, 0, 4'b0010, 16'h0060, 8'h44, 9);
        run_cyc(4'h0, 0, 4'b0010, 16'h0060, 8'h45, 10);
        run_cyc(4'h0, 0, 4'b0010, 16'h0060, 8'h46, 11);
        run_cyc(4'h0, 0, 4'b0000, 16'h0064, 8'h00, 9);
        run_cyc(4'h0, 0, 4'b0000, 16'h0064, 8'h00, 3);
        run_cyc(4'h0, 0, 4'b0000, 16'h0064, 8'h00, -1);
        // R10: every channel disabled
        m_en = '0;
        apply_cfg();
        run_cyc(4'h0, 0, 4'b0010, 16'h0060, 8'hEE, -1);
        run_cyc(4'h0, 0, 4'b0000, 16'h0064, 8'h00, -1);
        m_en = 4'b1111;
        apply_cfg();

        // seeded random mix
        for (int it = 0; it < 80; it++) begin
            int          r, ab, pre;
            logic [3:0]  ct, sn;
            r = int'($urandom % 100);
            if (r < 12) begin
                for (int i = 0; i < NCH; i++) m_addr[i] = pick_addr();
                m_en = 4'($urandom);
                m_ie = 4'($urandom);
                apply_cfg();
            end else if (r < 25) begin
                loc_write(int'($urandom % NCH), 8'($urandom));
            end else if (r < 35) begin
                loc_read(int'($urandom % NCH));
            end
            r = int'($urandom % 10);
            case (r)
                0: ct = 4'b0100;
                1: ct = 4'($urandom);
                2, 3, 4, 5: ct = 4'b0010;
                default: ct = 4'b0000;
            endcase
            ab  = (($urandom % 10) == 0) ? 2 + int'($urandom % 11) : -1;
            sn  = (($urandom % 20) == 0) ? 4'($urandom % 15) + 4'h1 : 4'h0;
            pre = (sn == 4'h0 && ($urandom % 10) == 0) ? 1 : 0;
            run_cyc(sn, pre, ct, pick_addr(), 8'($urandom), ab);
        end

        repeat (4) @(negedge clk);
        report();
    end

endmodule